// File: doc/BRIEF.md
# Clock-Loss Keepalive Sequencer

This controller sits next to a clock-management tile and protects it while its input reference is gone. It runs from a free-running clock of roughly 8 MHz that does not depend on the monitored reference. A presence indication for the reference and an optional feedback-presence indication arrive asynchronously, and both are resynchronised. When the reference is lost while the system is holding the tile in reset, the sequencer uses a simple configuration port to read three tile registers, at addresses 0x42, 0x51 and 0x4E. It parks the values in a small shift register and then writes zero to 0x4E, which silences the tile's outputs.

While the condition lasts, it repeats a four-step loop of calibration writes. The writes alternate between 0x42 and 0x51, so the tile's delay lines keep toggling. Once the reference returns or the hold request is withdrawn, the three saved values are written back in their original order. The tile's reset is then pulsed for a fixed number of cycles, and the sequencer goes back to idle.

Top module: `clkloss_keepalive`

## Requirements
- R1: While idle, the sequencer starts only when the synchronised inputs report a lost clock and `hold_req` is high. Loss with `hold_req` low leaves every output at zero.
- R2: The save phase performs three reads (`cfg_we`=0) in the order 0x42, 0x51, 0x4E. The read data returned with each ready strobe is kept for later restore.
- R3: Each access keeps `cfg_en`, `cfg_we`, `cfg_addr` and `cfg_wdata` stable until `cfg_rdy` is seen high with `cfg_en`. Exactly one step is taken per such completion, and `cfg_rdy` with `cfg_en` low has no effect.
- R4: After the third read, the sequencer writes 0x0000 to address 0x4E.
- R5: While the exit condition is absent, it repeats writes of CAL_V0, CAL_V1, CAL_V2 and CAL_V3 to 0x42, 0x51, 0x42 and 0x51 respectively, in that cyclic order.
- R6: The exit condition is that the clock is present again or `hold_req` is low. It is examined only when the 0x4E silencing write or a calibration write completes. On exit, the saved values are written back to 0x42, 0x51 and 0x4E, in that order.
- R7: After the last restore write completes, `tile_rst` is high for exactly RST_CYC consecutive cycles (RST_CYC >= 3) with no access in progress, and the sequencer then returns to idle.
- R8: A synchronous active-high `rst` puts the sequencer in idle with all outputs zero.
- R9: Each presence input passes through SYNC_STAGES flip-flops (reset value: present). With FB_CHECK=1, the clock counts as lost when either `ref_alive` or `fb_alive` is low. With FB_CHECK=0, only `ref_alive` counts.
- R10: Once started, the three reads and the silencing write always complete, even if the clock returns during them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_alive | input | 1 | Asynchronous presence flag of the monitored input clock |
| fb_alive | input | 1 | Asynchronous presence flag of the feedback clock |
| hold_req | input | 1 | System is holding the tile in reset |
| cfg_rdy | input | 1 | Configuration access complete strobe |
| cfg_rdata | input | DATA_W | Read data, valid with `cfg_rdy` |
| cfg_en | output | 1 | Configuration access request |
| cfg_we | output | 1 | 1 = write, 0 = read |
| cfg_addr | output | ADDR_W | Configuration address |
| cfg_wdata | output | DATA_W | Write data |
| tile_rst | output | 1 | Reset pulse to the tile |

## Verification
The two functions that can coincide are the return of the clock and the withdrawal of `hold_req`. Either can also land in the same cycle as the completion of a calibration write, which is where the exit decision is made. The bench releases both exit causes on the same edge and sweeps that edge across eight consecutive offsets inside the loop, so that each calibration step and the mid-access cycles are hit. A reference model, stepped per clock, tracks which write was in flight at that moment. It expects that write to finish and the restore to begin with 0x42. The bench then confirms that the tile register model holds its original values again.

// File: rtl/cka_pkg.sv
package cka_pkg;

  // Sequencer steps; the order of the save, loop and restore groups is behaviour.
  typedef enum logic [3:0] {
    S_IDLE,
    S_SAVE_A, S_SAVE_B, S_SAVE_C,
    S_MUTE,
    S_CAL0, S_CAL1, S_CAL2, S_CAL3,
    S_PUT_A, S_PUT_B, S_PUT_C,
    S_PULSE
  } seq_e;

  // Tile register addresses touched by the sequence.
  localparam logic [6:0] CKA_ADR_A = 7'h42;
  localparam logic [6:0] CKA_ADR_B = 7'h51;
  localparam logic [6:0] CKA_ADR_C = 7'h4E;

endpackage

// File: rtl/cka_sync.sv
module cka_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '1;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/cka_store.sv
module cka_store #(
  parameter int W     = 16,
  parameter int DEPTH = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] head
);

  // Rotating shift register: the oldest entry is always at index 0.
  logic [W-1:0] sr [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) sr[i] <= '0;
    end else if (push || pop) begin
      for (int i = 0; i < DEPTH-1; i++) sr[i] <= sr[i+1];
      sr[DEPTH-1] <= push ? din : sr[0];
    end
  end

  assign head = sr[0];

endmodule

// File: rtl/cka_seq.sv
module cka_seq
  import cka_pkg::*;
#(
  parameter int          ADDR_W  = 7,
  parameter int          DATA_W  = 16,
  parameter int          RST_CYC = 4,
  parameter logic [15:0] CAL_V0  = 16'h00F1,
  parameter logic [15:0] CAL_V1  = 16'h00E2,
  parameter logic [15:0] CAL_V2  = 16'h00D3,
  parameter logic [15:0] CAL_V3  = 16'h00C4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lost,
  input  logic              hold,
  input  logic              rdy,
  input  logic [DATA_W-1:0] head,
  output logic              push,
  output logic              pop,
  output logic              en,
  output logic              we,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic              tile_rst
);

  localparam int CW = $clog2(RST_CYC + 1);
  localparam logic [ADDR_W-1:0] AD_A = ADDR_W'(CKA_ADR_A);
  localparam logic [ADDR_W-1:0] AD_B = ADDR_W'(CKA_ADR_B);
  localparam logic [ADDR_W-1:0] AD_C = ADDR_W'(CKA_ADR_C);

  seq_e          st, nx;
  logic [CW-1:0] cnt;
  logic          done, leave;

  assign done  = en & rdy;
  assign leave = ~lost | ~hold;

  always_comb begin
    nx = st;
    unique case (st)
      S_IDLE:   if (lost && hold) nx = S_SAVE_A;
      S_SAVE_A: if (done) nx = S_SAVE_B;
      S_SAVE_B: if (done) nx = S_SAVE_C;
      S_SAVE_C: if (done) nx = S_MUTE;
      S_MUTE:   if (done) nx = leave ? S_PUT_A : S_CAL0;
      S_CAL0:   if (done) nx = leave ? S_PUT_A : S_CAL1;
      S_CAL1:   if (done) nx = leave ? S_PUT_A : S_CAL2;
      S_CAL2:   if (done) nx = leave ? S_PUT_A : S_CAL3;
      S_CAL3:   if (done) nx = leave ? S_PUT_A : S_CAL0;
      S_PUT_A:  if (done) nx = S_PUT_B;
      S_PUT_B:  if (done) nx = S_PUT_C;
      S_PUT_C:  if (done) nx = S_PULSE;
      S_PULSE:  if (cnt == CW'(RST_CYC - 1)) nx = S_IDLE;
      default:  nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      st  <= nx;
      cnt <= (st == S_PULSE) ? cnt + 1'b1 : '0;
    end
  end

  // Output decode straight from the state register.
  always_comb begin
    en       = 1'b0;
    we       = 1'b0;
    addr     = '0;
    wdata    = '0;
    tile_rst = 1'b0;
    unique case (st)
      S_SAVE_A: begin en = 1'b1; addr = AD_A; end
      S_SAVE_B: begin en = 1'b1; addr = AD_B; end
      S_SAVE_C: begin en = 1'b1; addr = AD_C; end
      S_MUTE:   begin en = 1'b1; we = 1'b1; addr = AD_C; end
      S_CAL0:   begin en = 1'b1; we = 1'b1; addr = AD_A; wdata = DATA_W'(CAL_V0); end
      S_CAL1:   begin en = 1'b1; we = 1'b1; addr = AD_B; wdata = DATA_W'(CAL_V1); end
      S_CAL2:   begin en = 1'b1; we = 1'b1; addr = AD_A; wdata = DATA_W'(CAL_V2); end
      S_CAL3:   begin en = 1'b1; we = 1'b1; addr = AD_B; wdata = DATA_W'(CAL_V3); end
      S_PUT_A:  begin en = 1'b1; we = 1'b1; addr = AD_A; wdata = head; end
      S_PUT_B:  begin en = 1'b1; we = 1'b1; addr = AD_B; wdata = head; end
      S_PUT_C:  begin en = 1'b1; we = 1'b1; addr = AD_C; wdata = head; end
      S_PULSE:  tile_rst = 1'b1;
      default:  ;
    endcase
  end

  assign push = done & ((st == S_SAVE_A) | (st == S_SAVE_B) | (st == S_SAVE_C));
  assign pop  = done & ((st == S_PUT_A)  | (st == S_PUT_B)  | (st == S_PUT_C));

endmodule

// File: rtl/clkloss_keepalive.sv
module clkloss_keepalive
  import cka_pkg::*;
#(
  parameter int          ADDR_W      = 7,
  parameter int          DATA_W      = 16,
  parameter int          SYNC_STAGES = 2,
  parameter int          RST_CYC     = 4,
  parameter bit          FB_CHECK    = 1'b1,
  parameter logic [15:0] CAL_V0      = 16'h00F1,
  parameter logic [15:0] CAL_V1      = 16'h00E2,
  parameter logic [15:0] CAL_V2      = 16'h00D3,
  parameter logic [15:0] CAL_V3      = 16'h00C4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_alive,
  input  logic              fb_alive,
  input  logic              hold_req,
  input  logic              cfg_rdy,
  input  logic [DATA_W-1:0] cfg_rdata,
  output logic              cfg_en,
  output logic              cfg_we,
  output logic [ADDR_W-1:0] cfg_addr,
  output logic [DATA_W-1:0] cfg_wdata,
  output logic              tile_rst
);

  localparam int SAVE_N = 3;

  if (RST_CYC < 3) begin : g_bad_rst
    $error("RST_CYC must be at least 3");
  end
  if (ADDR_W < 7) begin : g_bad_addr
    $error("ADDR_W must be at least 7");
  end

  logic [1:0]        alive_s;
  logic              lost;
  logic              push, pop;
  logic [DATA_W-1:0] head;

  cka_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({fb_alive, ref_alive}),
    .q   (alive_s)
  );

  if (FB_CHECK) begin : g_fb
    assign lost = ~(alive_s[0] & alive_s[1]);
  end else begin : g_nofb
    assign lost = ~alive_s[0];
  end

  cka_store #(.W(DATA_W), .DEPTH(SAVE_N)) u_store (
    .clk  (clk),
    .rst  (rst),
    .push (push),
    .pop  (pop),
    .din  (cfg_rdata),
    .head (head)
  );

  cka_seq #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .RST_CYC (RST_CYC),
    .CAL_V0 (CAL_V0), .CAL_V1 (CAL_V1), .CAL_V2 (CAL_V2), .CAL_V3 (CAL_V3)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .lost     (lost),
    .hold     (hold_req),
    .rdy      (cfg_rdy),
    .head     (head),
    .push     (push),
    .pop      (pop),
    .en       (cfg_en),
    .we       (cfg_we),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .tile_rst (tile_rst)
  );

endmodule

// File: rtl/cka_checker.sv
module cka_checker #(
  parameter int ADDR_W  = 7,
  parameter int DATA_W  = 16,
  parameter int RST_CYC = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_en,
  input logic              cfg_we,
  input logic              cfg_rdy,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [DATA_W-1:0] cfg_wdata,
  input logic              tile_rst
);

  localparam int CW = $clog2(RST_CYC + 1);
  localparam logic [ADDR_W-1:0] AD_A = ADDR_W'(7'h42);
  localparam logic [ADDR_W-1:0] AD_C = ADDR_W'(7'h4E);

  // Count of earlier consecutive cycles with tile_rst high.
  logic [CW-1:0] run;
  always_ff @(posedge clk) begin
    if (rst) run <= '0;
    else if (tile_rst) run <= (run == CW'(RST_CYC)) ? run : run + 1'b1;
    else run <= '0;
  end

  a_r3_hold_request: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && !cfg_rdy) |=> (cfg_en && $stable(cfg_we) && $stable(cfg_addr) && $stable(cfg_wdata)));

  a_r2_read_first: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_en) |-> (!cfg_we && cfg_addr == AD_A));

  a_r7_quiet_port: assert property (@(posedge clk) disable iff (rst)
    tile_rst |-> !cfg_en);

  a_r7_after_restore: assert property (@(posedge clk) disable iff (rst)
    $rose(tile_rst) |-> $past(cfg_en && cfg_we && cfg_rdy && cfg_addr == AD_C));

  a_r7_pulse_short: assert property (@(posedge clk) disable iff (rst)
    tile_rst |-> (run < CW'(RST_CYC)));

  a_r7_pulse_full: assert property (@(posedge clk) disable iff (rst)
    $fell(tile_rst) |-> (run == CW'(RST_CYC)));

endmodule

bind clkloss_keepalive cka_checker #(
  .ADDR_W (ADDR_W), .DATA_W (DATA_W), .RST_CYC (RST_CYC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_en    (cfg_en),
  .cfg_we    (cfg_we),
  .cfg_rdy   (cfg_rdy),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .tile_rst  (tile_rst)
);

// File: tb/clkloss_keepalive_tb.sv
module clkloss_keepalive_tb;

  localparam int          AW   = 7;
  localparam int          DW   = 16;
  localparam int          SYNC = 2;
  localparam int          RCYC = 4;
  localparam logic [15:0] CV0 = 16'h00F1, CV1 = 16'h00E2, CV2 = 16'h00D3, CV3 = 16'h00C4;
  localparam logic [15:0] INIT_A = 16'hA5C3, INIT_B = 16'h1E2F, INIT_C = 16'h0F0F;

  logic          clk = 1'b0;
  logic          rst, ref_alive, fb_alive, hold_req, cfg_rdy;
  logic [DW-1:0] cfg_rdata;
  logic          cfg_en, cfg_we, tile_rst;
  logic [AW-1:0] cfg_addr;
  logic [DW-1:0] cfg_wdata;

  always #10 clk = ~clk;

  clkloss_keepalive u_dut (
    .clk (clk), .rst (rst), .ref_alive (ref_alive), .fb_alive (fb_alive),
    .hold_req (hold_req), .cfg_rdy (cfg_rdy), .cfg_rdata (cfg_rdata),
    .cfg_en (cfg_en), .cfg_we (cfg_we), .cfg_addr (cfg_addr),
    .cfg_wdata (cfg_wdata), .tile_rst (tile_rst)
  );

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  // Tile register model and configuration port responder.
  logic [15:0] tile_a = INIT_A, tile_b = INIT_B, tile_c = INIT_C;
  int wcnt = 0, acc = 0, pulse_cycles = 0, cal_writes = 0;
  bit mute_seen = 0;

  // Reference model state.
  int          m_step = 0, m_cnt = 0;
  logic [15:0] saved[$];
  bit          q_ref[$], q_fb[$];
  logic [AW-1:0] p_addr; logic p_en = 0, p_rdy = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  function automatic string step_tag(input int s);
    if (s == 0) return "R1";
    if (s <= 3) return "R2";
    if (s == 4) return "R4";
    if (s <= 8) return "R5";
    if (s <= 11) return "R6";
    return "R7";
  endfunction

  function automatic logic [6:0] step_addr(input int s);
    case (s)
      1, 5, 7, 9:  return 7'h42;
      2, 6, 8, 10: return 7'h51;
      default:     return 7'h4E;
    endcase
  endfunction

  function automatic logic [15:0] step_data(input int s);
    case (s)
      5: return CV0;
      6: return CV1;
      7: return CV2;
      8: return CV3;
      9, 10, 11: return saved.size() > 0 ? saved[0] : 16'h0;
      default: return 16'h0;
    endcase
  endfunction

  always @(negedge clk) begin
    bit exp_en, exp_we, exp_rst, rdy_n, r_u, f_u, lost, leave;
    if (!rst && !finished) begin
      exp_en  = (m_step >= 1 && m_step <= 11);
      exp_we  = (m_step >= 4 && m_step <= 11);
      exp_rst = (m_step == 12);
      chk(cfg_en === exp_en, step_tag(m_step), cfg_en, exp_en);
      chk(tile_rst === exp_rst, step_tag(m_step), tile_rst, exp_rst);
      if (exp_en) begin
        chk(cfg_we === exp_we, step_tag(m_step), cfg_we, exp_we);
        chk(cfg_addr === AW'(step_addr(m_step)), step_tag(m_step), cfg_addr, step_addr(m_step));
        if (exp_we) chk(cfg_wdata === step_data(m_step), step_tag(m_step), cfg_wdata, step_data(m_step));
      end
      if (p_en && !p_rdy && cfg_en)  // R3: pending access held
        chk(cfg_addr === p_addr, "R3", cfg_addr, p_addr);
      if (tile_rst) pulse_cycles++;
    end
    // Responder: latency pattern 1..3 waiting cycles.
    rdy_n = 1'b0;
    if (rst) wcnt = 0;
    else if (cfg_en) begin
      if (wcnt >= 1 + (acc % 3)) begin rdy_n = 1'b1; wcnt = 0; acc++; end
      else wcnt++;
    end
    cfg_rdy   = rdy_n;
    cfg_rdata = '0;
    if (rdy_n && !cfg_we)
      cfg_rdata = (cfg_addr == 7'h42) ? tile_a : (cfg_addr == 7'h51) ? tile_b : tile_c;
    if (rdy_n && cfg_we) begin
      if (cfg_addr == 7'h42) tile_a = cfg_wdata;
      else if (cfg_addr == 7'h51) tile_b = cfg_wdata;
      else tile_c = cfg_wdata;
      if (cfg_addr == 7'h4E && cfg_wdata == 16'h0) mute_seen = 1;
      if (m_step >= 5 && m_step <= 8) cal_writes++;
    end
    p_en = cfg_en; p_rdy = rdy_n; p_addr = cfg_addr;
    // Reference model advance for the coming edge.
    if (rst) begin
      m_step = 0; m_cnt = 0; saved.delete(); q_ref.delete(); q_fb.delete();
      repeat (SYNC) begin q_ref.push_back(1'b1); q_fb.push_back(1'b1); end
    end else begin
      r_u = q_ref.pop_front(); q_ref.push_back(ref_alive);
      f_u = q_fb.pop_front();  q_fb.push_back(fb_alive);
      lost  = !(r_u && f_u);
      leave = !lost || !hold_req;
      case (m_step)
        0: if (lost && hold_req) m_step = 1;
        1, 2, 3: if (rdy_n) begin saved.push_back(cfg_rdata); m_step++; end
        4, 5, 6, 7, 8: if (rdy_n) m_step = leave ? 9 : (m_step == 8 ? 5 : m_step + 1);
        9, 10, 11: if (rdy_n) begin void'(saved.pop_front()); m_step++; m_cnt = 0; end
        12: begin m_cnt++; if (m_cnt == RCYC) m_step = 0; end
        default: m_step = 0;
      endcase
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic check_restored(input string tag);
    chk(tile_a == INIT_A, tag, tile_a, INIT_A);
    chk(tile_b == INIT_B, tag, tile_b, INIT_B);
    chk(tile_c == INIT_C, tag, tile_c, INIT_C);
  endtask

  task automatic report;
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int pulses_before;
    rst = 1; ref_alive = 1; fb_alive = 1; hold_req = 0; cfg_rdy = 0; cfg_rdata = '0;
    wait_cyc(4);
    rst = 0;
    @(negedge clk);
    chk(cfg_en == 0 && tile_rst == 0 && cfg_wdata == 0, "R8", {cfg_en, tile_rst}, 0);

    // R1: loss without hold request leaves everything quiet.
    wait_cyc(1); ref_alive = 0;
    wait_cyc(20);
    chk(cfg_en == 0 && tile_rst == 0, "R1", cfg_en, 0);
    ref_alive = 1; wait_cyc(4);

    // Main episode: clock loss under hold, exit on clock return.
    pulses_before = pulse_cycles; cal_writes = 0;
    hold_req = 1; ref_alive = 0;
    wait_cyc(60);
    chk(tile_c == 16'h0, "R4", tile_c, 0);
    chk(cal_writes >= 8, "R5", cal_writes, 8);
    ref_alive = 1;
    wait_cyc(80);
    check_restored("R6");
    chk(pulse_cycles - pulses_before == RCYC, "R7", pulse_cycles - pulses_before, RCYC);

    // Exit via hold release while clock stays absent.
    ref_alive = 0;
    wait_cyc(40);
    hold_req = 0;
    wait_cyc(80);
    check_restored("R6");
    chk(cfg_en == 0, "R1", cfg_en, 0);
    ref_alive = 1; wait_cyc(6);

    // R9: feedback loss alone triggers the sequence.
    pulses_before = pulse_cycles; mute_seen = 0;
    hold_req = 1; fb_alive = 0;
    wait_cyc(40);
    chk(mute_seen == 1, "R9", mute_seen, 1);
    fb_alive = 1;
    wait_cyc(80);
    check_restored("R9");
    chk(pulse_cycles - pulses_before == RCYC, "R9", pulse_cycles - pulses_before, RCYC);

    // R10: clock comes back during the save reads.
    mute_seen = 0;
    ref_alive = 0;
    wait_cyc(4);
    ref_alive = 1;
    wait_cyc(80);
    chk(mute_seen == 1, "R10", mute_seen, 1);
    check_restored("R10");

    // Both exit causes on the same edge, swept across the loop.
    for (int off = 0; off < 8; off++) begin
      hold_req = 1; ref_alive = 0;
      wait_cyc(24 + off);
      ref_alive = 1; hold_req = 0;
      wait_cyc(80);
      check_restored("R6");
    end
    wait_cyc(4);
    report();
  end

endmodule